// File: doc/BRIEF.md
# Interrupt Current-Priority Register with Preemption Stack

This block keeps the priority level of the interrupt handler that is running now, together with a small hardware stack of the levels that were interrupted on the way there. When the processor accepts an interrupt, the running level is saved on the stack and the accepted request's level takes its place. When a handler signals end-of-interrupt, the saved level comes back off the stack. Handlers therefore never save or restore the level themselves. Software may also overwrite the running level directly. That write leaves the saved levels alone.

The stack has fourteen four-bit slots. Nesting can reach fifteen levels, because a level-15 handler can never be interrupted. The block covers this with two rules. A save into a full stack drops the oldest entry. A restore from an empty stack returns level 0. The dropped bottom entry is always level 0, so the second rule rebuilds it.

Top module: `prio_stack_top`

## Requirements
- R1: After reset the current priority is 0 and the stack depth is 0.
- R2: An acknowledge with no end-of-interrupt saves the current priority on top of the stack and makes the acknowledged priority current. Both take effect at the next clock edge, and the depth rises by one unless it is already 14.
- R3: An end-of-interrupt with no acknowledge moves the top stack entry into the current priority at the next clock edge, and the depth falls by one.
- R4: Restores return saved priorities in the reverse of the order in which they were saved.
- R5: The depth never exceeds 14. A save into a full stack discards the oldest entry, so after 15 saves in a row the next 14 restores give the most recent 14 saved values, newest first.
- R6: An end-of-interrupt while the depth is 0 makes the current priority 0 and leaves the depth at 0.
- R7: When acknowledge and end-of-interrupt arrive in the same cycle, the restore is applied first and then the save and load. The current priority becomes the acknowledged priority. The stack top holds the restored value, or 0 if the stack was empty. The depth becomes the larger of its old value and 1.
- R8: A software write of the current priority, with no acknowledge or end-of-interrupt in that cycle, loads the written value at the next edge. It changes neither the depth nor any stack entry.
- R9: A software write in a cycle that also has an acknowledge or an end-of-interrupt has no effect. The acknowledge or restore result is what becomes current.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| ackValid | input | 1 | Interrupt acknowledged this cycle |
| ackPrio | input | 4 | Priority of the acknowledged request |
| eoiValid | input | 1 | End-of-interrupt event this cycle |
| swWrValid | input | 1 | Software write of the current priority |
| swWrPrio | input | 4 | Value carried by the software write |
| curPrio | output | 4 | Current running priority |
| stackDepth | output | 4 | Number of saved priorities (0 to 14) |

## Verification
The assertions assume that every input is a known value at each rising edge once reset is released. They also assume that a one-cycle pulse on the acknowledge, end-of-interrupt or write strobe means exactly one event. The assertions do not require an acknowledged priority to be above the current one, so the bench acknowledges repeated and lower levels as well as higher ones. The bench drives every input on the falling edge and holds each strobe for exactly one cycle, so each event is seen once and with stable data.

// File: rtl/prio_stack_pkg.sv
package prio_stack_pkg;
  typedef struct packed {
    logic push;     // save current priority on stack
    logic pop;      // restore from stack
    logic loadAck;  // current <= acknowledged priority
    logic loadSw;   // current <= software value
  } stackCtl_t;
endpackage

// File: rtl/prio_stack_ctrl.sv
module prio_stack_ctrl
  import prio_stack_pkg::*;
(
  input  logic      ackValid,
  input  logic      eoiValid,
  input  logic      swWrValid,
  output stackCtl_t ctl
);
  always_comb begin
    ctl.push    = ackValid;
    ctl.pop     = eoiValid;
    ctl.loadAck = ackValid;
    ctl.loadSw  = swWrValid && !ackValid && !eoiValid;
  end

  // software load never coincides with a stack event (R9)
  always_comb begin
    assert_sw_exclusive_R9: assert (!(ctl.loadSw && (ctl.push || ctl.pop)));
  end
endmodule

// File: rtl/prio_stack_dp.sv
module prio_stack_dp
  import prio_stack_pkg::*;
#(
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 14,
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  stackCtl_t          ctl,
  input  logic [PRIO_W-1:0]  ackPrio,
  input  logic [PRIO_W-1:0]  swWrPrio,
  output logic [PRIO_W-1:0]  curPrio,
  output logic [DEPTH_W-1:0] stackDepth
);
  localparam logic [DEPTH_W-1:0] DEPTH_C = DEPTH_W'(DEPTH);
  localparam logic [DEPTH_W-1:0] ONE_C   = DEPTH_W'(1);

  logic [PRIO_W-1:0] slot [DEPTH];
  logic [PRIO_W-1:0] popVal;
  logic [PRIO_W-1:0] pushVal;
  logic              isEmpty;

  assign isEmpty = (stackDepth == '0);
  assign popVal  = isEmpty ? '0 : slot[0];
  // with a same-cycle restore, the restored value is what gets saved
  assign pushVal = ctl.pop ? popVal : curPrio;

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_slot
      logic [PRIO_W-1:0] fromAbove;
      logic [PRIO_W-1:0] fromBelow;
      if (i == 0) begin : g_top
        assign fromAbove = pushVal;
      end else begin : g_mid
        assign fromAbove = slot[i-1];
      end
      if (i == DEPTH - 1) begin : g_bot
        assign fromBelow = '0;
      end else begin : g_up
        assign fromBelow = slot[i+1];
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slot[i] <= '0;
        end else begin
          unique case ({ctl.push, ctl.pop})
            2'b10:   slot[i] <= fromAbove;
            2'b01:   slot[i] <= fromBelow;
            2'b11:   if (i == 0) slot[i] <= pushVal;
            default: slot[i] <= slot[i];
          endcase
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackDepth <= '0;
    end else begin
      unique case ({ctl.push, ctl.pop})
        2'b10:   if (stackDepth != DEPTH_C) stackDepth <= stackDepth + ONE_C;
        2'b01:   if (!isEmpty) stackDepth <= stackDepth - ONE_C;
        2'b11:   if (isEmpty) stackDepth <= ONE_C;
        default: stackDepth <= stackDepth;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            curPrio <= '0;
    else if (ctl.loadAck) curPrio <= ackPrio;
    else if (ctl.pop)     curPrio <= popVal;
    else if (ctl.loadSw)  curPrio <= swWrPrio;
  end

  assert_ack_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadAck |=> curPrio == $past(ackPrio));

  assert_grow_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.push && !ctl.pop && stackDepth != DEPTH_C) |=>
      stackDepth == $past(stackDepth) + ONE_C);

  assert_shrink_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pop && !ctl.push && !isEmpty) |=>
      stackDepth == $past(stackDepth) - ONE_C);

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth <= DEPTH_C);

  assert_pop_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pop && !ctl.push && isEmpty) |=> (curPrio == '0 && stackDepth == '0));

  assert_both_nonempty_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.pop && ctl.push) |=> stackDepth != '0);

  assert_sw_depth_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadSw |=> $stable(stackDepth));
endmodule

// File: rtl/prio_stack_top.sv
module prio_stack_top
  import prio_stack_pkg::*;
#(
  parameter int PRIO_W = 4,
  parameter int DEPTH  = 14,
  localparam int DEPTH_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ackValid,
  input  logic [PRIO_W-1:0]  ackPrio,
  input  logic               eoiValid,
  input  logic               swWrValid,
  input  logic [PRIO_W-1:0]  swWrPrio,
  output logic [PRIO_W-1:0]  curPrio,
  output logic [DEPTH_W-1:0] stackDepth
);
  stackCtl_t ctl;

  prio_stack_ctrl u_ctrl (
    .ackValid (ackValid),
    .eoiValid (eoiValid),
    .swWrValid(swWrValid),
    .ctl      (ctl)
  );

  prio_stack_dp #(.PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .ackPrio   (ackPrio),
    .swWrPrio  (swWrPrio),
    .curPrio   (curPrio),
    .stackDepth(stackDepth)
  );
endmodule

// File: tb/tb_prio_stack_top.sv
module tb_prio_stack_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ackValid = 1'b0;
  logic [3:0] ackPrio = '0;
  logic       eoiValid = 1'b0;
  logic       swWrValid = 1'b0;
  logic [3:0] swWrPrio = '0;
  logic [3:0] curPrio;
  logic [3:0] stackDepth;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench reference: index 0 is the top of the stack
  int mCur = 0;
  int mStk[$];

  always #4 clk = ~clk;  // 125 MHz

  prio_stack_top dut (
    .clk(clk), .rstN(rstN), .ackValid(ackValid), .ackPrio(ackPrio),
    .eoiValid(eoiValid), .swWrValid(swWrValid), .swWrPrio(swWrPrio),
    .curPrio(curPrio), .stackDepth(stackDepth)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle of stimulus, reference update, then compare at the falling edge
  task automatic step(input bit a, input int ap, input bit e, input bit s,
                      input int sp, input string tag);
    int popped;
    ackValid = a; ackPrio = 4'(ap); eoiValid = e; swWrValid = s; swWrPrio = 4'(sp);
    if (e) begin
      popped = (mStk.size() > 0) ? mStk.pop_front() : 0;
      mCur = popped;
    end
    if (a) begin
      mStk.push_front(mCur);
      if (mStk.size() > 14) void'(mStk.pop_back());
      mCur = ap;
    end
    if (s && !a && !e) mCur = sp;
    @(negedge clk);
    ackValid = 0; eoiValid = 0; swWrValid = 0;
    check(tag, int'(curPrio), mCur, "curPrio");
    check(tag, int'(stackDepth), mStk.size(), "stackDepth");
  endtask

  task automatic drain(input string tag);
    while (mStk.size() > 0) step(0, 0, 1, 0, 0, tag);
  endtask

  task automatic testReset();
    check("R1", int'(curPrio), 0, "curPrio after reset");
    check("R1", int'(stackDepth), 0, "stackDepth after reset");
  endtask

  task automatic testNest();
    step(1, 3, 0, 0, 0, "R2");
    step(1, 7, 0, 0, 0, "R2");
    step(1, 12, 0, 0, 0, "R2");
    step(1, 5, 0, 0, 0, "R2");   // lower level still saved
    step(0, 0, 1, 0, 0, "R3");
    step(0, 0, 1, 0, 0, "R4");
    step(0, 0, 1, 0, 0, "R4");
    step(0, 0, 1, 0, 0, "R4");
  endtask

  task automatic testOverflow();
    for (int k = 1; k <= 15; k++) step(1, k, 0, 0, 0, "R5");
    check("R5", int'(stackDepth), 14, "depth saturates");
    for (int k = 0; k < 14; k++) step(0, 0, 1, 0, 0, "R5");
    step(0, 0, 1, 0, 0, "R6");
  endtask

  task automatic testEmptyPop();
    step(0, 0, 1, 0, 0, "R6");
    step(0, 0, 1, 0, 0, "R6");
  endtask

  task automatic testBoth();
    step(1, 9, 1, 0, 0, "R7");   // empty stack: stores 0, depth 1
    step(1, 4, 0, 0, 0, "R7");
    step(1, 11, 1, 0, 0, "R7");
    drain("R7");
  endtask

  task automatic testSw();
    step(1, 2, 0, 0, 0, "R8");
    step(1, 6, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 13, "R8");
    step(0, 0, 0, 1, 1, "R8");
    drain("R8");                 // saved levels 2 and 0 unchanged
  endtask

  task automatic testSwIgnored();
    step(1, 8, 0, 1, 14, "R9");
    step(1, 10, 0, 0, 0, "R9");
    step(0, 0, 1, 1, 15, "R9");
    step(1, 3, 1, 1, 15, "R9");
    drain("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNest();
    testOverflow();
    testEmptyPop();
    testBoth();
    testSw();
    testSwIgnored();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule